// File: doc/BRIEF.md
# Power-Mode-Aware Capture Timer

An 8-bit up-counter that advances once for each falling edge of a selected divided clock. Three of the selectable sources are taps of a free-running divider on the system clock: clock/4, clock/16 and clock/64. The fourth is a slow asynchronous subclock divided by four. That source crosses into the system clock domain through a two-flop synchronizer. Edge detection runs on the output of the source multiplexer, so changing the selection can itself produce a falling edge, and therefore a count.

A 3-bit power-mode input decides whether the counter runs in the present mode with the present clock selection. A CPU-subclock setting input also takes part in that decision. A capture input is synchronized and edge-detected. Its rising edge copies the count into one capture register and its falling edge copies it into the other. Either capture sets a flag. In interval mode, captures are disabled and a wrap of the counter from 0xFF to 0x00 sets an overflow flag. A single clear strobe clears both flags.

Top module: `capture_timer`

## Requirements
- R1: While reset is asserted and directly after it, the count, both capture registers, the capture flag and the overflow flag are all zero.
- R2: When running, the count advances by exactly one per period of the selected system source. The clock-select codes are 0 for clock/4, 1 for clock/16 and 2 for clock/64.
- R3: Clock-select code 3 picks subclock/4, which is synchronized into the system domain. Over any window, the number of increments is within one of the number of subclock/4 falling edges in that window.
- R4: A selection change from a source that is high to one that is low adds exactly one count. A change from low to high adds none. A rising edge of the selected source never counts.
- R5: Power-mode codes are 0 active, 1 sleep, 2 watch, 3 subactive, 4 subsleep, 5 standby, 6 module-standby and 7 reserved. In active and sleep modes the counter runs with any selection. In watch mode it runs only with code 3. When it is halted, capture edges are ignored.
- R6: In subactive and subsleep modes, the counter runs only when clock-select is 3 and the CPU-subclock setting is 2. The setting codes are 0 for /8, 1 for /4 and 2 for /2. Any other combination halts the counter.
- R7: In standby, module-standby and the reserved code, the count holds. The capture registers and flags keep their values, and capture edges are ignored.
- R8: When the counter runs outside interval mode, a rising capture edge loads the count into the rising capture register. A falling edge loads it into the falling capture register. Either edge sets the capture flag. The result is visible within five clocks of the input change.
- R9: A one-cycle clear strobe clears the capture flag and the overflow flag. If a flag-setting event occurs in the same cycle, the flag stays set.
- R10: In interval mode, the wrap from 0xFF to 0x00 sets the overflow flag and capture edges are ignored. Outside interval mode, the count wraps without setting the flag.
- R11: The count never changes by anything other than plus one, modulo 256, from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subClk | input | 1 | Slow subclock, asynchronous to clk |
| clkSel | input | 2 | Counter clock source select |
| subDiv | input | 2 | CPU subclock setting (0 /8, 1 /4, 2 /2) |
| powerMode | input | 3 | Current power mode code |
| intervalMode | input | 1 | 1 selects interval mode |
| capIn | input | 1 | Asynchronous capture input |
| flagClr | input | 1 | One-cycle clear strobe for both flags |
| count | output | 8 | Counter value |
| capFall | output | 8 | Count captured on a falling capture edge |
| capRise | output | 8 | Count captured on a rising capture edge |
| capFlag | output | 1 | Set by any capture |
| ovfFlag | output | 1 | Set by an interval-mode wrap |

## Verification
A wrong run decision shows up as a count that moves, or does not move, within one period of the selected source. For the slowest system source that is 64 clocks, and for the subclock source it is 32 clocks. A broken edge detector or a broken source switch changes the count by one, within a few clocks of the selection write. A wrong capture path leaves a capture register or the flag wrong within five clocks of the capture input changing. A missing wrap flag appears after 1024 clocks at clock/4.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_WATCH    = 3'd2,
    PM_SUBACT   = 3'd3,
    PM_SUBSLEEP = 3'd4,
    PM_STANDBY  = 3'd5,
    PM_MODSTBY  = 3'd6,
    PM_RSVD     = 3'd7
  } pwrMode_e;

  localparam logic [1:0] SUBDIV_HALF = 2'd2;

  typedef struct packed {
    logic incr;
    logic capFall;
    logic capRise;
    logic flagClr;
    logic interval;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import capture_timer_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SUB_DIV_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             subClk,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [1:0]       subDiv,
  input  logic [2:0]       powerMode,
  input  logic             intervalMode,
  input  logic             capIn,
  input  logic             flagClr,
  output tmrStrobe_t       strobe
);

  localparam int NUM_SRC     = 2 ** SEL_W;
  localparam int NUM_SYS_SRC = NUM_SRC - 1;
  localparam int SYS_DIV_W   = 2 * NUM_SYS_SRC;
  localparam logic [SEL_W-1:0] SUB_SEL = SEL_W'(NUM_SRC - 1);

  logic [SYS_DIV_W-1:0]   sysDiv;
  logic [SUB_DIV_W-1:0]   subCnt;
  logic [SYNC_STAGES-1:0] subSyncQ;
  logic [SYNC_STAGES-1:0] capSyncQ;
  logic [NUM_SRC-1:0]     srcVec;
  logic                   srcNow, srcPrev, capPrev, capNow, run, subSelected;
  pwrMode_e               mode;

  // system-clock prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysDiv <= '0;
    else       sysDiv <= sysDiv + 1'b1;
  end

  // subclock-domain divider
  always_ff @(posedge subClk or negedge rstN) begin
    if (!rstN) subCnt <= '0;
    else       subCnt <= subCnt + 1'b1;
  end

  // synchronizers for the subclock tap and the capture input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subSyncQ <= '0;
      capSyncQ <= '0;
    end else begin
      subSyncQ <= {subSyncQ[SYNC_STAGES-2:0], subCnt[SUB_DIV_W-1]};
      capSyncQ <= {capSyncQ[SYNC_STAGES-2:0], capIn};
    end
  end

  generate
    for (genvar i = 0; i < NUM_SYS_SRC; i++) begin : g_tap
      assign srcVec[i] = sysDiv[2*i+1];
    end
  endgenerate
  assign srcVec[NUM_SRC-1] = subSyncQ[SYNC_STAGES-1];

  assign srcNow      = srcVec[clkSel];
  assign capNow      = capSyncQ[SYNC_STAGES-1];
  assign mode        = pwrMode_e'(powerMode);
  assign subSelected = (clkSel == SUB_SEL);

  always_comb begin
    unique case (mode)
      PM_ACTIVE, PM_SLEEP:    run = 1'b1;
      PM_WATCH:               run = subSelected;
      PM_SUBACT, PM_SUBSLEEP: run = subSelected && (subDiv == SUBDIV_HALF);
      default:                run = 1'b0;
    endcase
  end

  // edge detectors run in every mode, so leaving a halt adds no count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      srcPrev <= srcNow;
      capPrev <= capNow;
    end
  end

  always_comb begin
    strobe.incr     = srcPrev & ~srcNow & run;
    strobe.capFall  = capPrev & ~capNow & run & ~intervalMode;
    strobe.capRise  = ~capPrev & capNow & run & ~intervalMode;
    strobe.flagClr  = flagClr;
    strobe.interval = intervalMode;
  end

  // R4
  rise_no_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcPrev && srcNow) |-> !strobe.incr);

  // R5
  watch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == PM_WATCH && !subSelected) |-> !(strobe.incr || strobe.capFall || strobe.capRise));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import capture_timer_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  output logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] capFall,
  output logic [COUNT_W-1:0] capRise,
  output logic               capFlag,
  output logic               ovfFlag
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      capFall <= '0;
      capRise <= '0;
      capFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (strobe.incr) count <= count + 1'b1;
      if (strobe.capFall) capFall <= count;
      if (strobe.capRise) capRise <= count;
      if (strobe.capFall || strobe.capRise) capFlag <= 1'b1;
      else if (strobe.flagClr)              capFlag <= 1'b0;
      if (strobe.incr && strobe.interval && count == COUNT_MAX) ovfFlag <= 1'b1;
      else if (strobe.flagClr)                                  ovfFlag <= 1'b0;
    end
  end

  // R10
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(count) == COUNT_MAX && count == '0));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> count == COUNT_W'($past(count) + 1'b1));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagClr && !strobe.capFall && !strobe.capRise) |=> !capFlag);

endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import capture_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       subClk,
  input  logic [1:0] clkSel,
  input  logic [1:0] subDiv,
  input  logic [2:0] powerMode,
  input  logic       intervalMode,
  input  logic       capIn,
  input  logic       flagClr,
  output logic [7:0] count,
  output logic [7:0] capFall,
  output logic [7:0] capRise,
  output logic       capFlag,
  output logic       ovfFlag
);

  tmrStrobe_t strobe;

  tmr_ctrl #(.SEL_W(2), .SUB_DIV_W(2), .SYNC_STAGES(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .subClk(subClk), .clkSel(clkSel), .subDiv(subDiv),
    .powerMode(powerMode), .intervalMode(intervalMode), .capIn(capIn),
    .flagClr(flagClr), .strobe(strobe)
  );

  tmr_datapath #(.COUNT_W(8)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count),
    .capFall(capFall), .capRise(capRise), .capFlag(capFlag), .ovfFlag(ovfFlag)
  );

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerMode >= 3'd5) |=> ($stable(count) && $stable(capFall) && $stable(capRise) && $stable(capFlag)));

  // R10
  interval_nocap_chk: assert property (@(posedge clk) disable iff (!rstN)
    intervalMode |=> ($stable(capFall) && $stable(capRise)));

  // R6
  sub_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((powerMode == 3'd3 || powerMode == 3'd4) && (clkSel != 2'd3 || subDiv != 2'd2)) |=> $stable(count));

endmodule

// File: tb/test_capture_timer.sv
module test_capture_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       subClk = 1'b0;
  logic [1:0] clkSel = '0;
  logic [1:0] subDiv = 2'd2;
  logic [2:0] powerMode = '0;
  logic       intervalMode = 1'b0;
  logic       capIn = 1'b0;
  logic       flagClr = 1'b0;
  logic [7:0] count, capFall, capRise;
  logic       capFlag, ovfFlag;
  logic       subRun = 1'b0;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  capture_timer i_capture_timer (
    .clk(clk), .rstN(rstN), .subClk(subClk), .clkSel(clkSel), .subDiv(subDiv),
    .powerMode(powerMode), .intervalMode(intervalMode), .capIn(capIn),
    .flagClr(flagClr), .count(count), .capFall(capFall), .capRise(capRise),
    .capFlag(capFlag), .ovfFlag(ovfFlag)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      #80;
      if (subRun) subClk = ~subClk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    subRun = 1'b0;
    #200;
    subClk = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    clkSel = '0; subDiv = 2'd2; powerMode = '0; intervalMode = 1'b0;
    capIn = 1'b0; flagClr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic subPulse(input int n);
    for (int i = 0; i < n; i++) begin
      #80 subClk = 1'b1;
      #80 subClk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic measure(input int n, output int d);
    logic [7:0] c0;
    @(negedge clk);
    c0 = count;
    repeat (n) @(negedge clk);
    d = int'(8'(count - c0));
  endtask

  task automatic pulseClr();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d, exp;
    logic [7:0] c, c2, capV;
    bit runs;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk(count == 0, "R1", "count in reset", count, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(count == 0, "R1", "count after reset", count, 0);
    chk(capFall == 0, "R1", "capFall", capFall, 0);
    chk(capRise == 0, "R1", "capRise", capRise, 0);
    chk(capFlag == 0, "R1", "capFlag", capFlag, 0);
    chk(ovfFlag == 0, "R1", "ovfFlag", ovfFlag, 0);

    // R2, R5, R6, R7: sweep power mode x system source, subclock stopped
    for (int pm = 0; pm < 8; pm++) begin
      for (int sel = 0; sel < 3; sel++) begin
        @(negedge clk);
        powerMode = 3'(pm);
        clkSel = 2'(sel);
        repeat (70) @(negedge clk);
        measure(3 * (4 << (2 * sel)), d);
        exp = (pm <= 1) ? 3 : 0;
        chk(d == exp, (pm <= 1) ? "R2" : (pm == 2 ? "R5" : (pm <= 4 ? "R6" : "R7")),
            $sformatf("delta pm=%0d sel=%0d", pm, sel), d, exp);
      end
    end

    // R3, R5, R6: subclock/4 source, 8 falling edges per 256 clocks
    subRun = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      clkSel = 2'd3;
      case (k)
        0: begin powerMode = 3'd0; subDiv = 2'd0; end
        1: begin powerMode = 3'd2; subDiv = 2'd0; end
        2, 3, 4, 5: begin powerMode = 3'd3; subDiv = 2'(k - 2); end
        6: begin powerMode = 3'd4; subDiv = 2'd2; end
        default: begin powerMode = 3'd5; subDiv = 2'd2; end
      endcase
      runs = (k <= 1) || (k == 4) || (k == 6);
      repeat (70) @(negedge clk);
      measure(256, d);
      if (runs) chk(d >= 7 && d <= 9, k == 0 ? "R3" : (k == 1 ? "R5" : "R6"),
                    $sformatf("sub delta case %0d", k), d, 8);
      else      chk(d == 0, k == 7 ? "R7" : "R6", $sformatf("sub delta case %0d", k), d, 0);
    end

    // R4: source switching, with subclock under manual control
    doReset();
    @(negedge clk);
    powerMode = 3'd0;
    clkSel = 2'd3;
    repeat (10) @(negedge clk);
    c = count;
    subPulse(2);
    repeat (10) @(negedge clk);
    chk(count == c, "R4", "rising sub edge", count, c);
    subPulse(2);
    repeat (10) @(negedge clk);
    chk(count == 8'(c + 1), "R3", "falling sub edge", count, c + 1);
    subPulse(2);
    repeat (10) @(negedge clk);
    c = count;
    clkSel = 2'd2;
    for (int i = 0; i < 100 && count == c; i++) @(negedge clk);
    c2 = count;
    for (int i = 0; i < 100 && count == c2; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    c = count;
    clkSel = 2'd3;
    repeat (8) @(negedge clk);
    chk(count == c, "R4", "low to high switch", count, c);
    clkSel = 2'd2;
    repeat (5) @(negedge clk);
    chk(count == 8'(c + 1), "R4", "high to low switch", count, c + 1);
    clkSel = 2'd3;
    repeat (5) @(negedge clk);
    capV = count;

    // R8, R9: capture with a frozen count
    capIn = 1'b1;
    repeat (5) @(negedge clk);
    chk(capRise == capV, "R8", "capRise value", capRise, capV);
    chk(capFlag == 1, "R8", "capFlag on rise", capFlag, 1);
    pulseClr();
    chk(capFlag == 0, "R9", "capFlag cleared", capFlag, 0);
    capIn = 1'b0;
    repeat (5) @(negedge clk);
    chk(capFall == capV, "R8", "capFall value", capFall, capV);
    chk(capFlag == 1, "R8", "capFlag on fall", capFlag, 1);
    subPulse(4);
    repeat (5) @(negedge clk);
    capIn = 1'b1;
    repeat (5) @(negedge clk);
    chk(capRise == 8'(capV + 1), "R8", "capRise after step", capRise, capV + 1);
    chk(capFall == capV, "R8", "capFall kept", capFall, capV);

    // R7: standby ignores capture, keeps registers
    pulseClr();
    powerMode = 3'd5;
    capIn = 1'b0;
    repeat (6) @(negedge clk);
    chk(capFall == capV, "R7", "capFall in standby", capFall, capV);
    chk(capFlag == 0, "R7", "capFlag in standby", capFlag, 0);
    // R5: watch with a system source ignores capture
    powerMode = 3'd2;
    clkSel = 2'd0;
    capIn = 1'b1;
    repeat (6) @(negedge clk);
    chk(capRise == 8'(capV + 1), "R5", "capRise in halted watch", capRise, capV + 1);
    chk(capFlag == 0, "R5", "capFlag in halted watch", capFlag, 0);

    // R10: interval mode wrap and capture lockout
    powerMode = 3'd0;
    intervalMode = 1'b1;
    pulseClr();
    repeat (1100) @(negedge clk);
    chk(ovfFlag == 1, "R10", "ovfFlag after wrap", ovfFlag, 1);
    capIn = 1'b0;
    repeat (6) @(negedge clk);
    chk(capFall == capV, "R10", "capFall in interval", capFall, capV);
    pulseClr();
    chk(ovfFlag == 0, "R9", "ovfFlag cleared", ovfFlag, 0);
    intervalMode = 1'b0;
    repeat (1100) @(negedge clk);
    chk(ovfFlag == 0, "R10", "no flag outside interval", ovfFlag, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule